// File: doc/BRIEF.md
# Streaming 2x Pyramid Upsampler

This block takes a raster-order stream of 8-bit pixels for a frame of W by H pixels and returns a frame of 2W by 2H pixels. Conceptually each input pixel (r,c) is placed at (2r,2c) and every other position is zero. The sparse image is smoothed with a fixed separable 5x5 Gaussian whose taps per axis are 1,4,6,4,1, and a gain of four restores the brightness lost to the zeros. Samples that fall outside the image are found by mirroring about the edge, and the edge sample itself is not repeated.

Frame geometry comes from `width_i` and `height_i`, which are latched together with the start-of-frame pixel. Both sides use valid/ready handshakes. Input rows go into a four-row ring of line storage. The output side walks the 2W by 2H raster, one pixel per cycle. Each output pixel is computed from a 3x3 neighbourhood of stored input pixels.

Top module: `pyr_up`

## Requirements
- R1: For a frame with 2 <= W <= MAX_W and 2 <= H <= MAX_H, latched when the start-of-frame pixel is accepted, the block accepts exactly W*H input pixels and emits exactly 2W*2H output pixels in raster order.
- R2: `out_sof_o` is high only on the first output pixel of a frame. `out_eol_o` is high exactly on the last pixel (column 2W-1) of every output row.
- R3: Output pixel (y,x) equals (4*S + 128) >> 8. S is the sum over dy,dx in -2..2 of k[dy]*k[dx]*P(y+dy,x+dx), where k = 1,4,6,4,1 and P(y,x) is input (y/2,x/2) when y and x are both even, and 0 otherwise.
- R4: Positions outside the 2H by 2W padded image are mirrored without repeating the edge: index -1 reads index 1, and index 2N reads index 2N-2.
- R5: The result is rounded half-up by the +128 term and clamped to 0..255. A constant input image of value k gives a constant output of k.
- R6: With NCH channels packed in one word, channel n sits in bits [8n+7:8n] on both sides. Each channel is filtered independently with the same arithmetic.
- R7: While `out_valid_o` is high and `out_ready_i` is low, the output data and markers hold their values until the transfer completes.
- R8: Once the rows a pair of output rows needs are stored, input is accepted only on cycles in which an even-row, even-column output pixel advances. A stalled output therefore blocks input.
- R9: While no frame is active, `in_ready_o` is high. Input pixels without `in_sof_i` are discarded and do not affect the next frame.
- R10: With input always valid and output always ready, the 4*W*H output pixels of a frame leave on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| width_i | input | $clog2(MAX_W+1) | Input frame width, latched with the start-of-frame pixel |
| height_i | input | $clog2(MAX_H+1) | Input frame height, latched with the start-of-frame pixel |
| in_valid_i | input | 1 | Input pixel valid |
| in_ready_o | output | 1 | Input pixel accepted when high together with valid |
| in_data_i | input | 8*NCH | Input pixel, channel n in bits [8n+7:8n] |
| in_sof_i | input | 1 | Marks the first pixel of an input frame |
| out_valid_o | output | 1 | Output pixel valid |
| out_ready_i | input | 1 | Downstream accepts the output pixel |
| out_data_o | output | 8*NCH | Output pixel |
| out_sof_o | output | 1 | First output pixel of the frame |
| out_eol_o | output | 1 | Last output pixel of a row |

## Verification
An output pixel is registered one edge after its raster position advances. An input pixel is written one edge after it is accepted, and `in_ready_o` responds in the same cycle to `out_ready_i`. The bench therefore drives inputs at the falling edge, waits one time unit, and reads both handshakes for the rising edge that follows. Expected pixels come from a direct 5x5 sum over the zero-inserted, mirrored image. Each output is compared at the cycle its transfer completes, so no fixed latency is assumed. Hold behaviour is checked on the cycle after each stalled cycle. Throughput is checked as the number of cycles between the first and last output transfer.

// File: rtl/pyr_up_pkg.sv
package pyr_up_pkg;
  localparam int CH_W = 8;
  typedef enum logic {ST_IDLE, ST_ACTIVE} pu_state_e;
endpackage

// File: rtl/pyr_up_linebuf.sv
module pyr_up_linebuf #(
  parameter int PW    = 8,
  parameter int MAX_W = 64,
  parameter int AW    = $clog2(MAX_W)
) (
  input  logic                     clk_i,
  input  logic                     we_i,
  input  logic [1:0]               wslot_i,
  input  logic [AW-1:0]            waddr_i,
  input  logic [PW-1:0]            wdata_i,
  input  logic [2:0][1:0]          rslot_i,
  input  logic [2:0][AW-1:0]       raddr_i,
  output logic [2:0][2:0][PW-1:0]  rdata_o
);
  // four-row ring: three rows read while the fourth fills
  logic [PW-1:0] mem_q [4][MAX_W];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[wslot_i][waddr_i] <= wdata_i;
  end

  for (genvar i = 0; i < 3; i++) begin : g_row
    for (genvar j = 0; j < 3; j++) begin : g_col
      assign rdata_o[i][j] = mem_q[rslot_i[i]][raddr_i[j]];
    end
  end
endmodule

// File: rtl/pyr_up_kernel.sv
module pyr_up_kernel (
  input  logic [2:0][2:0][7:0] win_i,   // [row r-1,r,r+1][col c-1,c,c+1]
  input  logic                 vodd_i,
  input  logic                 hodd_i,
  output logic [7:0]           pix_o
);
  logic [2:0][10:0] v;
  logic [13:0]      h;
  logic [8:0]       q;

  // polyphase form of [1 4 6 4 1] on a zero-inserted axis
  always_comb begin
    for (int j = 0; j < 3; j++) begin
      if (vodd_i) v[j] = (11'(win_i[1][j]) + 11'(win_i[2][j])) << 2;
      else        v[j] = 11'(win_i[0][j]) + 11'(win_i[1][j]) * 11'd6 + 11'(win_i[2][j]);
    end
    if (hodd_i) h = (14'(v[1]) + 14'(v[2])) << 2;
    else        h = 14'(v[0]) + 14'(v[1]) * 14'd6 + 14'(v[2]);
    q     = 9'((15'(h) + 15'd32) >> 6);
    pix_o = (q > 9'd255) ? 8'hff : q[7:0];
  end
endmodule

// File: rtl/pyr_up.sv
module pyr_up
  import pyr_up_pkg::*;
#(
  parameter int NCH   = 1,
  parameter int MAX_W = 64,
  parameter int MAX_H = 64
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [$clog2(MAX_W+1)-1:0]      width_i,
  input  logic [$clog2(MAX_H+1)-1:0]      height_i,
  input  logic                            in_valid_i,
  output logic                            in_ready_o,
  input  logic [NCH*CH_W-1:0]             in_data_i,
  input  logic                            in_sof_i,
  output logic                            out_valid_o,
  input  logic                            out_ready_i,
  output logic [NCH*CH_W-1:0]             out_data_o,
  output logic                            out_sof_o,
  output logic                            out_eol_o
);
  localparam int PW  = NCH * CH_W;
  localparam int AW  = $clog2(MAX_W);
  localparam int WW  = $clog2(MAX_W + 1);
  localparam int HW  = $clog2(MAX_H + 1);
  localparam int OCW = WW + 1;

  pu_state_e      st_q;
  logic [WW-1:0]  w_q, ld_col_q;
  logic [HW-1:0]  h_q, ld_row_q, orow_q;
  logic           vodd_q;
  logic [OCW-1:0] ocol_q;
  logic           ov_q, osof_q, oeol_q;
  logic [PW-1:0]  od_q;

  logic           active, rows_ok, ld_room, step, acc, last_col;
  logic [HW:0]    orow_p2, need;

  assign active   = (st_q == ST_ACTIVE);
  assign orow_p2  = {1'b0, orow_q} + (HW+1)'(2);
  assign need     = (orow_p2 > {1'b0, h_q}) ? {1'b0, h_q} : orow_p2;
  assign rows_ok  = ({1'b0, ld_row_q} >= need);
  assign ld_room  = (ld_row_q < h_q) && ({1'b0, ld_row_q} <= orow_p2);
  assign step     = active && rows_ok && (!ov_q || out_ready_i);
  assign last_col = (ocol_q == {w_q, 1'b0} - 1'b1);

  // input paced to even-row/even-column output steps once rows are present
  assign in_ready_o = !active ||
                      (ld_room && (!rows_ok || (step && !vodd_q && !ocol_q[0])));
  assign acc = in_valid_i && in_ready_o;

  // window addressing with mirrored borders
  logic [WW-1:0] ic, cm, cp;
  logic [HW-1:0] rm, rp;
  assign ic = ocol_q[OCW-1:1];
  assign cm = (ic == '0) ? WW'(1) : ic - 1'b1;
  assign cp = (ic == w_q - 1'b1) ? ic : ic + 1'b1;
  assign rm = (orow_q == '0) ? HW'(1) : orow_q - 1'b1;
  assign rp = (orow_q == h_q - 1'b1) ? orow_q : orow_q + 1'b1;

  logic [2:0][1:0]         rslot;
  logic [2:0][AW-1:0]      raddr;
  logic [2:0][2:0][PW-1:0] rd;
  assign rslot = {rp[1:0], orow_q[1:0], rm[1:0]};
  assign raddr = {AW'(cp), AW'(ic), AW'(cm)};

  pyr_up_linebuf #(.PW(PW), .MAX_W(MAX_W), .AW(AW)) u_lb (
    .clk_i   (clk_i),
    .we_i    (acc && (active || in_sof_i)),
    .wslot_i (active ? ld_row_q[1:0] : 2'd0),
    .waddr_i (active ? AW'(ld_col_q) : '0),
    .wdata_i (in_data_i),
    .rslot_i (rslot),
    .raddr_i (raddr),
    .rdata_o (rd)
  );

  logic [PW-1:0] pix;
  for (genvar n = 0; n < NCH; n++) begin : g_ch
    logic [2:0][2:0][7:0] win;
    for (genvar i = 0; i < 3; i++) begin : g_i
      for (genvar j = 0; j < 3; j++) begin : g_j
        assign win[i][j] = rd[i][j][n*CH_W +: CH_W];
      end
    end
    pyr_up_kernel u_k (
      .win_i  (win),
      .vodd_i (vodd_q),
      .hodd_i (ocol_q[0]),
      .pix_o  (pix[n*CH_W +: CH_W])
    );
  end

  // frame sequencing and input row fill
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      w_q      <= '0;
      h_q      <= '0;
      ld_row_q <= '0;
      ld_col_q <= '0;
      orow_q   <= '0;
      vodd_q   <= 1'b0;
      ocol_q   <= '0;
    end else if (!active) begin
      if (acc && in_sof_i) begin
        st_q     <= ST_ACTIVE;
        w_q      <= width_i;
        h_q      <= height_i;
        ld_row_q <= '0;
        ld_col_q <= WW'(1);
        orow_q   <= '0;
        vodd_q   <= 1'b0;
        ocol_q   <= '0;
      end
    end else begin
      if (acc) begin
        if (ld_col_q == w_q - 1'b1) begin
          ld_col_q <= '0;
          ld_row_q <= ld_row_q + 1'b1;
        end else begin
          ld_col_q <= ld_col_q + 1'b1;
        end
      end
      if (step) begin
        if (last_col) begin
          ocol_q <= '0;
          vodd_q <= !vodd_q;
          if (vodd_q) begin
            if (orow_q == h_q - 1'b1) st_q <= ST_IDLE;
            else                      orow_q <= orow_q + 1'b1;
          end
        end else begin
          ocol_q <= ocol_q + 1'b1;
        end
      end
    end
  end

  // output register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ov_q   <= 1'b0;
      od_q   <= '0;
      osof_q <= 1'b0;
      oeol_q <= 1'b0;
    end else if (step) begin
      ov_q   <= 1'b1;
      od_q   <= pix;
      osof_q <= (orow_q == '0) && !vodd_q && (ocol_q == '0);
      oeol_q <= last_col;
    end else if (out_ready_i) begin
      ov_q   <= 1'b0;
    end
  end

  assign out_valid_o = ov_q;
  assign out_data_o  = od_q;
  assign out_sof_o   = osof_q;
  assign out_eol_o   = oeol_q;

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o)
                                    && $stable(out_sof_o) && $stable(out_eol_o));

  p_stall_blocks_in_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active && rows_ok && out_valid_o && !out_ready_i |-> !in_ready_o);

  p_odd_row_no_in_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active && rows_ok && vodd_q |-> !in_ready_o);

  p_sof_not_eol_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_sof_o |-> !out_eol_o);

  p_ring_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active |-> ({1'b0, ld_row_q} <= orow_p2 + 1'b1));
endmodule

// File: tb/sim_pyr_up.sv
module sim_pyr_up;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 3;
  localparam int MW  = 16;
  localparam int MH  = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [4:0] width, height;
  logic in_valid = 1'b0, in_ready, in_sof = 1'b0;
  logic [23:0] in_data = '0;
  logic out_valid, out_ready = 1'b0, out_sof, out_eol;
  logic [23:0] out_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  pyr_up #(.NCH(NCH), .MAX_W(MW), .MAX_H(MH)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .width_i(width), .height_i(height),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data), .in_sof_i(in_sof),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data),
    .out_sof_o(out_sof), .out_eol_o(out_eol)
  );

  int n_chk = 0, n_fail = 0;
  int img [3][MH][MW];
  int expv[3][2*MH][2*MW];
  int first_oc, last_oc, held_acc;

  task automatic chk(input bit ok, input string req, input int act, input int ex);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, ex);
    end
  endtask

  function automatic int refl(input int i, input int n);
    if (i < 0)  return -i;
    if (i >= n) return 2*n - 2 - i;
    return i;
  endfunction

  function automatic int kw(input int d);
    case (d)
      -2, 2:   return 1;
      -1, 1:   return 4;
      default: return 6;
    endcase
  endfunction

  task automatic compute_ref(input int w, input int h);
    for (int ch = 0; ch < 3; ch++)
      for (int y = 0; y < 2*h; y++)
        for (int x = 0; x < 2*w; x++) begin
          int s = 0;
          for (int dy = -2; dy <= 2; dy++)
            for (int dx = -2; dx <= 2; dx++) begin
              int yy = refl(y+dy, 2*h);
              int xx = refl(x+dx, 2*w);
              if (yy % 2 == 0 && xx % 2 == 0)
                s += kw(dy) * kw(dx) * img[ch][yy/2][xx/2];
            end
          s = (4*s + 128) >> 8;
          expv[ch][y][x] = (s > 255) ? 255 : s;
        end
  endtask

  // pat: 0 ramp, 1 random, 2 constant k
  task automatic fill(input int w, input int h, input int pat, input int k);
    for (int ch = 0; ch < 3; ch++)
      for (int r = 0; r < h; r++)
        for (int c = 0; c < w; c++)
          case (pat)
            0:       img[ch][r][c] = (r*37 + c*11 + ch*50) % 256;
            1:       img[ch][r][c] = $urandom_range(0, 255);
            default: img[ch][r][c] = k;
          endcase
    compute_ref(w, h);
  endtask

  // mode bits: 1 input gaps, 2 output stalls, 4 one long hold, 8 idle junk first
  task automatic run_frame(input int w, input int h, input int mode, input string tag);
    int idx = 0, oi = 0, cyc = 0, hold_cnt = 0;
    bit prev_stall = 0, in_hold;
    logic [23:0] prev_d = '0;
    logic prev_sof = 0, prev_eol = 0;
    width = 5'(w); height = 5'(h); held_acc = 0;
    if (mode & 8) begin
      for (int j = 0; j < 3; j++) begin
        @(negedge clk);
        in_valid = 1'b1; in_sof = 1'b0; in_data = 24'hffffff;
        #1;
        chk(in_ready === 1'b1, "R9 idle ready", int'(in_ready), 1);
      end
    end
    while (oi < 4*w*h && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      in_valid = (idx < w*h) && !((mode & 1) && (cyc % 3 == 1));
      in_sof   = (idx == 0);
      for (int ch = 0; ch < 3; ch++)
        in_data[ch*8 +: 8] = 8'(img[ch][(idx < w*h ? idx : 0)/w][(idx < w*h ? idx : 0)%w]);
      out_ready = !((mode & 2) && (cyc % 5 == 2 || cyc % 7 == 3));
      in_hold = (mode & 4) && oi >= 5 && hold_cnt < 12;
      if (in_hold) begin
        out_ready = 1'b0;
        hold_cnt++;
      end
      #1;
      if (in_hold && in_valid && in_ready) held_acc++;
      if (prev_stall)
        chk(out_valid && out_data === prev_d && out_sof === prev_sof && out_eol === prev_eol,
            "R7 hold", int'(out_data), int'(prev_d));
      if (in_valid && in_ready) idx++;
      if (out_valid && out_ready) begin
        int y = oi / (2*w), x = oi % (2*w);
        for (int ch = 0; ch < NCH; ch++)
          chk(int'(out_data[ch*8 +: 8]) == expv[ch][y][x], tag,
              int'(out_data[ch*8 +: 8]), expv[ch][y][x]);
        chk(out_sof === (oi == 0), "R2 sof", int'(out_sof), int'(oi == 0));
        chk(out_eol === (x == 2*w-1), "R2 eol", int'(out_eol), int'(x == 2*w-1));
        if (oi == 0) first_oc = cyc;
        last_oc = cyc;
        oi++;
      end
      prev_stall = out_valid && !out_ready;
      prev_d = out_data; prev_sof = out_sof; prev_eol = out_eol;
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; out_ready = 1'b1;
    chk(oi == 4*w*h, "R1 output count", oi, 4*w*h);
    chk(idx == w*h, "R1 input count", idx, w*h);
  endtask

  task automatic t_reset();
    #1;
    chk(out_valid === 1'b0, "R2 reset out_valid", int'(out_valid), 0);
    chk(in_ready === 1'b1, "R9 reset in_ready", int'(in_ready), 1);
  endtask

  task automatic t_ramp();
    fill(4, 3, 0, 0);
    run_frame(4, 3, 0, "R3 ramp");
    chk(last_oc - first_oc == 4*4*3 - 1, "R10 back-to-back", last_oc - first_oc, 47);
  endtask

  task automatic t_border();
    fill(2, 2, 1, 0);
    run_frame(2, 2, 0, "R4 border 2x2");
    fill(7, 5, 1, 0);
    run_frame(7, 5, 0, "R4 border 7x5");
  endtask

  task automatic t_const();
    fill(3, 2, 2, 255);
    run_frame(3, 2, 0, "R5 const 255");
    fill(5, 3, 2, 99);
    run_frame(5, 3, 0, "R5 const 99");
  endtask

  task automatic t_channels();
    fill(5, 4, 1, 0);
    run_frame(5, 4, 0, "R6 channels");
  endtask

  task automatic t_stall();
    fill(6, 4, 1, 0);
    run_frame(6, 4, 3, "R7 stalled data");
  endtask

  task automatic t_hold();
    fill(6, 3, 0, 0);
    run_frame(6, 3, 4, "R8 hold data");
    chk(held_acc == 0, "R8 no input during stall", held_acc, 0);
  endtask

  task automatic t_idle();
    fill(3, 3, 1, 0);
    run_frame(3, 3, 8, "R9 after junk");
  endtask

  task automatic t_max();
    fill(MW, 2, 1, 0);
    run_frame(MW, 2, 0, "R1 max width");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    width = 5'd2; height = 5'd2;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_ramp();
    t_border();
    t_const();
    t_channels();
    t_stall();
    t_hold();
    t_idle();
    t_max();
    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule